// File: doc/BRIEF.md
# LIN Transceiver Power-Mode Sequencer

This block is the digital mode controller for a LIN physical-layer transceiver that carries its own supply regulator. A host controller steers it with one chip-select/wake line. The bus side can wake the block through a dominant level that lasts long enough. Digital flags report the battery, the regulator and overload events. From these inputs the block decides when the regulator is on and when the bus transmitter may drive. It also reports the current mode as a 3-bit code.

After the battery becomes good, the block enters one of two standby modes, chosen by the chip-select level. For a fixed lockout window it ignores chip-select edges so that a host still coming out of its own reset cannot start transmission by accident. Power-down can only be entered from the transmitting mode. From power-down, the block wakes either on a chip-select rising edge or on bus activity that passes a debounce. An overload of any kind sends it back to the alternate standby mode, so the host has to toggle chip-select again before it can transmit. Every timer is a counter on the system clock whose tick count is a parameter.

Top module: `lin_pwr_seq`

## Requirements
- R1: While `bat_good` is low (a synchronous reset that must last at least 3 clock cycles), `mode_code` is 0, and `tx_en` and `reg_en` are both 0.
- R2: On the first clock edge with `bat_good` high, the synchronized chip-select level selects the mode. Low gives ready (code 1) and high gives alternate ready (code 2). In both modes `reg_en` is 1 and `tx_en` is 0.
- R3: For `LOCK_TICKS` cycles after `bat_good` rises, chip-select edges are ignored. Alternate ready moves to ready only once the lockout has ended and chip-select is low.
- R4: In ready, once the lockout has ended, a chip-select rising edge enters operation (code 3) with `tx_en` and `reg_en` both 1, at most 3 clock edges after the input changes. `tx_en` is never 1 without `reg_en`.
- R5: In operation, a chip-select falling edge enters power-down (code 4) with both enables at 0. Power-down is never entered from any other mode.
- R6: In power-down, `bus_dom` held high for `DEB_TICKS` consecutive synchronized samples enters wake (code 5), with `reg_en` 1 and `tx_en` 0. A shorter pulse has no effect.
- R7: Wake stays in wake until `reg_good` is high, then enters ready.
- R8: In power-down, a chip-select rising edge enters operation directly, ahead of any bus wake.
- R9: In any mode with the regulator on, `ovl_therm` or `ovl_bus` enters hold (code 6), with `tx_en` 0 and `reg_en` 1. Once both flags clear, the block moves to alternate ready.
- R10: In any mode with the regulator on, `ovl_reg` or a falling edge of `reg_good` enters regulator-off (code 7), with both enables at 0. This takes priority over R9. After `REC_TICKS` cycles the block moves to alternate ready with `reg_en` 1.
- R11: After an overload return, transmission resumes only after chip-select has gone low and then risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| bat_good | input | 1 | Battery supply good; low acts as synchronous reset |
| reg_good | input | 1 | Regulator output above its shutdown threshold |
| cs_wake | input | 1 | Chip-select/wake from host, asynchronous |
| bus_dom | input | 1 | Bus receiver sees dominant, asynchronous |
| ovl_therm | input | 1 | Thermal overload flag |
| ovl_bus | input | 1 | Bus driver overload flag |
| ovl_reg | input | 1 | Regulator overload flag |
| tx_en | output | 1 | Bus transmitter enable |
| reg_en | output | 1 | Regulator enable |
| mode_code | output | 3 | Current mode, encoded as in R1 to R10 |

## Verification
The situations hardest to reach from the ports are the ones that depend on the block's history. A chip-select edge that must be rejected only because the lockout window is still open is one. A falling edge on chip-select while the block sits in ready is another, and it can only be produced inside that lockout, because outside it any rise would already have entered operation. The stimulus reaches these cases by changing chip-select shortly after `bat_good` rises and checking the mode code before the window expires. Overload priority is tested by raising the regulator overload while the block is already held by a thermal or bus overload, and also together with one. The debounce is tested with one pulse at half the required length and one just past it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    M_POR     = 3'd0,
    M_RDY     = 3'd1,
    M_RDY_ALT = 3'd2,
    M_OPER    = 3'd3,
    M_PDN     = 3'd4,
    M_WAKE    = 3'd5,
    M_HOLD    = 3'd6,
    M_REGOFF  = 3'd7
  } lpm_mode_e;

  // counter width able to hold the value ticks
  function automatic int f_cnt_w(input int ticks);
    return (ticks < 1) ? 1 : $clog2(ticks + 1);
  endfunction

  function automatic logic f_reg_on(input lpm_mode_e m);
    return (m == M_RDY) || (m == M_RDY_ALT) || (m == M_OPER) ||
           (m == M_WAKE) || (m == M_HOLD);
  endfunction

  function automatic logic f_tx_on(input lpm_mode_e m);
    return m == M_OPER;
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end

endmodule

// File: rtl/lpm_timer.sv
module lpm_timer
  import lpm_pkg::*;
#(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic clr,
  output logic done
);

  localparam int W = f_cnt_w(TICKS);
  localparam logic [W-1:0] LIM = W'(TICKS);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)        cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_lvl,
  input  logic      cs_rise,
  input  logic      cs_fall,
  input  logic      lock_act,
  input  logic      deb_done,
  input  logic      rec_done,
  input  logic      reg_good,
  input  logic      reg_fail,
  input  logic      ovl_tb,
  input  logic      ovl_reg,
  output lpm_mode_e mode
);

  lpm_mode_e nxt;
  logic      rise_ok, fall_ok, supply_bad;

  assign rise_ok    = cs_rise && !lock_act;
  assign fall_ok    = cs_fall && !lock_act;
  assign supply_bad = ovl_reg || reg_fail;

  always_comb begin
    nxt = mode;
    if (f_reg_on(mode) && supply_bad) begin
      nxt = M_REGOFF;
    end else if (f_reg_on(mode) && ovl_tb && mode != M_HOLD) begin
      nxt = M_HOLD;
    end else begin
      case (mode)
        M_POR:     nxt = cs_lvl ? M_RDY_ALT : M_RDY;
        M_RDY:     if (rise_ok) nxt = M_OPER;
        M_RDY_ALT: if (!lock_act && !cs_lvl) nxt = M_RDY;
        M_OPER:    if (fall_ok) nxt = M_PDN;
        M_WAKE:    if (reg_good) nxt = M_RDY;
        M_HOLD:    if (!ovl_tb) nxt = M_RDY_ALT;
        M_PDN: begin
          if (rise_ok)       nxt = M_OPER;
          else if (deb_done) nxt = M_WAKE;
        end
        M_REGOFF:  if (rec_done) nxt = M_RDY_ALT;
        default:   nxt = M_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= M_POR;
    else     mode <= nxt;
  end

endmodule

// File: rtl/lin_pwr_seq.sv
module lin_pwr_seq
  import lpm_pkg::*;
#(
  parameter int LOCK_TICKS  = 75000,
  parameter int DEB_TICKS   = 3125,
  parameter int REC_TICKS   = 625000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       bat_good,
  input  logic       reg_good,
  input  logic       cs_wake,
  input  logic       bus_dom,
  input  logic       ovl_therm,
  input  logic       ovl_bus,
  input  logic       ovl_reg,
  output logic       tx_en,
  output logic       reg_en,
  output logic [2:0] mode_code
);

  logic      rst;
  logic      cs_s, bus_s, cs_p, reg_good_q;
  logic      cs_rise, cs_fall, reg_fail;
  logic      lock_done, lock_act, deb_done, rec_done;
  logic      deb_clr, rec_clr;
  lpm_mode_e mode;

  assign rst = !bat_good;

  lpm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({bus_dom, cs_wake}),
    .q   ({bus_s, cs_s})
  );

  always_ff @(posedge clk) begin
    cs_p <= cs_s;
    if (rst) reg_good_q <= 1'b0;
    else     reg_good_q <= reg_good;
  end

  assign cs_rise  = cs_s && !cs_p;
  assign cs_fall  = !cs_s && cs_p;
  assign reg_fail = reg_good_q && !reg_good;

  // start-up lockout, counted from the end of reset
  lpm_timer #(.TICKS(LOCK_TICKS)) u_lock (
    .clk (clk), .clr (rst), .done (lock_done)
  );
  assign lock_act = !lock_done;

  // bus wake debounce, only while powered down and bus dominant
  assign deb_clr = rst || !(mode == M_PDN && bus_s);
  lpm_timer #(.TICKS(DEB_TICKS)) u_deb (
    .clk (clk), .clr (deb_clr), .done (deb_done)
  );

  // regulator recovery wait
  assign rec_clr = rst || (mode != M_REGOFF);
  lpm_timer #(.TICKS(REC_TICKS)) u_rec (
    .clk (clk), .clr (rec_clr), .done (rec_done)
  );

  lpm_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cs_lvl   (cs_s),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .lock_act (lock_act),
    .deb_done (deb_done),
    .rec_done (rec_done),
    .reg_good (reg_good),
    .reg_fail (reg_fail),
    .ovl_tb   (ovl_therm || ovl_bus),
    .ovl_reg  (ovl_reg),
    .mode     (mode)
  );

  assign tx_en     = f_tx_on(mode);
  assign reg_en    = f_reg_on(mode);
  assign mode_code = mode;

  AST_TX_NEEDS_REG: assert property (@(posedge clk) disable iff (!bat_good)
    tx_en |-> reg_en); // R4

  AST_LOCK_BLOCKS_OPER: assert property (@(posedge clk) disable iff (!bat_good)
    (lock_act && mode == M_RDY) |=> (mode != M_OPER)); // R3

  AST_PDN_ONLY_FROM_OPER: assert property (@(posedge clk) disable iff (!bat_good)
    (mode == M_PDN && $past(mode) != M_PDN) |-> ($past(mode) == M_OPER)); // R5

  AST_WAKE_DEBOUNCED: assert property (@(posedge clk) disable iff (!bat_good)
    (mode == M_WAKE && $past(mode) == M_PDN) |-> $past(deb_done)); // R6

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!bat_good)
    ($past(mode) == M_HOLD && mode != M_HOLD) |->
      (mode == M_RDY_ALT || mode == M_REGOFF)); // R9

  AST_REGOFF_EXIT: assert property (@(posedge clk) disable iff (!bat_good)
    ($past(mode) == M_REGOFF && mode != M_REGOFF) |->
      (mode == M_RDY_ALT && $past(rec_done))); // R10

endmodule

// File: tb/tb_lin_pwr_seq.sv
module tb_lin_pwr_seq;

  localparam int LOCK = 200;
  localparam int DEB  = 40;
  localparam int REC  = 100;

  logic clk = 1'b0;
  logic bat_good = 1'b0, reg_good = 1'b0, cs_wake = 1'b0, bus_dom = 1'b0;
  logic ovl_therm = 1'b0, ovl_bus = 1'b0, ovl_reg = 1'b0;
  logic tx_en, reg_en;
  logic [2:0] mode_code;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lin_pwr_seq #(.LOCK_TICKS(LOCK), .DEB_TICKS(DEB), .REC_TICKS(REC)) dut (
    .clk(clk), .bat_good(bat_good), .reg_good(reg_good), .cs_wake(cs_wake),
    .bus_dom(bus_dom), .ovl_therm(ovl_therm), .ovl_bus(ovl_bus),
    .ovl_reg(ovl_reg), .tx_en(tx_en), .reg_en(reg_en), .mode_code(mode_code)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] m,
                     input logic tx, input logic rg);
    n_vec++;
    if (mode_code !== m || tx_en !== tx || reg_en !== rg) begin
      n_bad++;
      $display("FAIL %s: mode/tx/reg = %0d/%0b/%0b, expected %0d/%0b/%0b",
               req, mode_code, tx_en, reg_en, m, tx, rg);
    end
  endtask

  task automatic t_reset(input logic cs_lvl, input logic [2:0] exp_m);
    bat_good = 1'b0; cs_wake = cs_lvl; reg_good = 1'b0; bus_dom = 1'b0;
    ovl_therm = 1'b0; ovl_bus = 1'b0; ovl_reg = 1'b0;
    tick(4);
    chk("R1", 3'd0, 1'b0, 1'b0);
    bat_good = 1'b1;
    tick(1);
    chk("R2", exp_m, 1'b0, 1'b1);
  endtask

  task automatic t_por_low;
    t_reset(1'b0, 3'd1);
    reg_good = 1'b1;
    cs_wake = 1'b1; tick(4);
    chk("R3 rise in lockout", 3'd1, 1'b0, 1'b1);
    cs_wake = 1'b0; tick(4);
    chk("R5 fall in ready", 3'd1, 1'b0, 1'b1);
    tick(LOCK);
    cs_wake = 1'b1; tick(4);
    chk("R4", 3'd3, 1'b1, 1'b1);
  endtask

  task automatic t_oper_to_pdn;
    cs_wake = 1'b0; tick(4);
    chk("R5", 3'd4, 1'b0, 1'b0);
    reg_good = 1'b0; tick(2);
  endtask

  task automatic t_bus_glitch;
    bus_dom = 1'b1; tick(DEB / 2);
    bus_dom = 1'b0; tick(6);
    chk("R6 short pulse", 3'd4, 1'b0, 1'b0);
  endtask

  task automatic t_bus_wake;
    bus_dom = 1'b1; tick(DEB + 6);
    chk("R6 wake", 3'd5, 1'b0, 1'b1);
    bus_dom = 1'b0; tick(3);
    chk("R7 wait", 3'd5, 1'b0, 1'b1);
    reg_good = 1'b1; tick(2);
    chk("R7", 3'd1, 1'b0, 1'b1);
  endtask

  task automatic t_pdn_cs_wake;
    cs_wake = 1'b1; tick(4);
    chk("R4 again", 3'd3, 1'b1, 1'b1);
    cs_wake = 1'b0; tick(4);
    chk("R5 again", 3'd4, 1'b0, 1'b0);
    reg_good = 1'b0;
    bus_dom = 1'b1; cs_wake = 1'b1; tick(4);
    chk("R8", 3'd3, 1'b1, 1'b1);
    bus_dom = 1'b0; reg_good = 1'b1; tick(2);
  endtask

  task automatic t_thermal;
    ovl_therm = 1'b1; tick(2);
    chk("R9 hold", 3'd6, 1'b0, 1'b1);
    ovl_therm = 1'b0; tick(2);
    chk("R9 exit", 3'd2, 1'b0, 1'b1);
    tick(5);
    chk("R11 cs still high", 3'd2, 1'b0, 1'b1);
    cs_wake = 1'b0; tick(4);
    chk("R11 cs low", 3'd1, 1'b0, 1'b1);
    cs_wake = 1'b1; tick(4);
    chk("R11 resume", 3'd3, 1'b1, 1'b1);
  endtask

  task automatic t_bus_ovl_then_reg;
    ovl_bus = 1'b1; tick(2);
    chk("R9 bus ovl", 3'd6, 1'b0, 1'b1);
    ovl_reg = 1'b1; tick(2);
    chk("R10 from hold", 3'd7, 1'b0, 1'b0);
    ovl_bus = 1'b0; ovl_reg = 1'b0; tick(REC + 5);
    chk("R10 recover", 3'd2, 1'b0, 1'b1);
    cs_wake = 1'b0; tick(4);
    cs_wake = 1'b1; tick(4);
    chk("R11", 3'd3, 1'b1, 1'b1);
  endtask

  task automatic t_reg_drop;
    reg_good = 1'b0; tick(2);
    chk("R10 reg fall", 3'd7, 1'b0, 1'b0);
    tick(REC / 2);
    chk("R10 waiting", 3'd7, 1'b0, 1'b0);
    reg_good = 1'b1; tick(REC);
    chk("R10 recover", 3'd2, 1'b0, 1'b1);
  endtask

  task automatic t_priority;
    cs_wake = 1'b0; tick(4);
    chk("R11", 3'd1, 1'b0, 1'b1);
    cs_wake = 1'b1; tick(4);
    chk("R4", 3'd3, 1'b1, 1'b1);
    ovl_reg = 1'b1; ovl_therm = 1'b1; tick(2);
    chk("R10 priority", 3'd7, 1'b0, 1'b0);
    ovl_reg = 1'b0; ovl_therm = 1'b0; tick(REC + 5);
    chk("R10 recover", 3'd2, 1'b0, 1'b1);
  endtask

  task automatic t_por_high;
    t_reset(1'b1, 3'd2);
    reg_good = 1'b1;
    tick(4);
    cs_wake = 1'b0; tick(4);
    chk("R3 alt held in lockout", 3'd2, 1'b0, 1'b1);
    tick(LOCK);
    chk("R3 alt to ready", 3'd1, 1'b0, 1'b1);
    cs_wake = 1'b1; tick(4);
    chk("R4", 3'd3, 1'b1, 1'b1);
    bat_good = 1'b0; tick(3);
    chk("R1 battery loss", 3'd0, 1'b0, 1'b0);
  endtask

  initial begin
    tick(1);
    t_por_low();
    t_oper_to_pdn();
    t_bus_glitch();
    t_bus_wake();
    t_pdn_cs_wake();
    t_thermal();
    t_bus_ovl_then_reg();
    t_reg_drop();
    t_priority();
    t_por_high();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule